// File: doc/BRIEF.md
# Multi-Policy Round-Robin Stream Collector

This block merges NUM_SRC valid-ready source streams into a single valid-ready output stream. It is the receiving end of a work-distribution scheme: a front end spreads items over parallel workers, and the collector gathers their results back into one stream. It neither buffers items nor changes them. The chosen source's data and valid go to the output combinationally, and the downstream ready goes back only to that source.

The arbitration policy is a static parameter and takes one of three values. In the waiting policy a rotation pointer picks exactly one source and stays on it until that source completes a transfer. This keeps the gathered stream in strict order, but an idle worker stalls every other worker. In the skipping policy the same pointer moves past a source that has nothing to offer and checks the next one on the following cycle. In the priority policy all sources are examined at once and the lowest-numbered source with data wins. The priority policy needs no pointer, but its selection logic grows with NUM_SRC.

A clock enable freezes the block. While it is low, no transfer can complete and the pointer holds its value.

Top module: `rr_stream_collector`

## Requirements
- R1: In the waiting policy (MODE=0) the output presents only the source named by the pointer. When that source has no valid item, out_valid is low and the pointer does not move.
- R2: In the waiting policy, a pointed-at source that stays idle blocks the output even when other sources hold valid items.
- R3: In the skipping policy (MODE=1), if the pointed-at source is not valid while enabled, the pointer moves to the next source, wrapping at the end, on the following cycle.
- R4: In the priority policy (MODE=2) the output carries the lowest-indexed valid source in the same cycle. If no source is valid, the index used is 0.
- R5: In both rotation policies a completed transfer (out_valid and out_ready both high) moves the pointer to the next index, and the index after NUM_SRC-1 is 0.
- R6: At most one src_ready bit is high, namely the bit of the selected source, and it equals out_ready while enabled.
- R7: Reset puts the pointer on source 0.
- R8: While en is low, out_valid and every src_ready bit are low and the pointer holds its value.
- R9: out_data equals the selected source's lane of src_data in the same cycle. Lane i occupies bits [i*DATA_W +: DATA_W].
- R10: In the rotation policies, a valid pointed-at source facing out_ready low keeps the pointer where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Clock enable; low freezes the block |
| src_valid | input | NUM_SRC | Per-source valid, bit i for source i |
| src_data | input | NUM_SRC*DATA_W | Source payloads, lane i at [i*DATA_W +: DATA_W] |
| src_ready | output | NUM_SRC | Per-source ready, bit i for source i |
| out_valid | output | 1 | Output item valid |
| out_data | output | DATA_W | Output payload |
| out_ready | input | 1 | Downstream ready |

## Verification
The outputs are combinational from the inputs and the pointer. out_valid, out_data and src_ready therefore belong to the same cycle as the stimulus, and the bench samples them two nanoseconds after driving new inputs on the falling edge. The pointer is the only register, so a transfer or a skip shows up in the selection one rising edge later. The bench's own pointer models advance right after that edge and are compared on the next falling-edge stimulus. One instance of each policy sees identical stimulus, first in directed ordering runs, then in a full sweep of valid masks, ready and enable, and then in a long pseudo-random run.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

  typedef enum logic [1:0] {
    COLLECT_WAIT = 2'd0,
    COLLECT_SKIP = 2'd1,
    COLLECT_PRIO = 2'd2
  } collect_mode_e;

  // Width of an index able to name n sources (at least one bit).
  function automatic int unsigned rrc_idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Successor of a rotation index, wrapping at n.
  function automatic int unsigned rrc_wrap_next(input int unsigned cur,
                                                input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/rrc_pointer.sv
module rrc_pointer #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned IDX_W   = rrc_pkg::rrc_idx_width(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step_req,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] ptr_next;
  logic             do_step;

  assign do_step  = en & step_req;
  assign ptr_next = IDX_W'(rrc_pkg::rrc_wrap_next(int'(ptr), NUM_SRC));

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (do_step) ptr <= ptr_next;
  end

  // R5: the last index wraps to zero
  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && ptr == IDX_W'(NUM_SRC - 1)) |=> (ptr == '0));

  // R8: a disabled block keeps its pointer
  a_r8_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ptr));

endmodule

// File: rtl/rrc_chooser.sv
module rrc_chooser #(
  parameter int unsigned           NUM_SRC = 4,
  parameter rrc_pkg::collect_mode_e MODE   = rrc_pkg::COLLECT_WAIT,
  parameter int unsigned           IDX_W   = rrc_pkg::rrc_idx_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [NUM_SRC-1:0] src_valid,
  input  logic               out_ready,
  output logic [IDX_W-1:0]   sel,
  output logic               sel_valid,
  output logic               sel_hs
);

  generate
    if (MODE == rrc_pkg::COLLECT_PRIO) begin : g_prio
      logic [IDX_W-1:0] win;
      logic             found;

      always_comb begin
        win   = '0;
        found = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
          if (src_valid[i]) begin
            win   = IDX_W'(i);
            found = 1'b1;
          end
        end
      end

      assign sel       = win;
      assign sel_valid = found;
      assign sel_hs    = en & found & out_ready;

      // R4: nothing below the winner is valid
      a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((src_valid & ((NUM_SRC'(1) << win) - NUM_SRC'(1))) == '0));

    end else begin : g_rot
      logic [IDX_W-1:0] ptr;
      logic             cur_valid;
      logic             step_req;

      assign cur_valid = src_valid[ptr];
      assign sel       = ptr;
      assign sel_valid = cur_valid;
      assign sel_hs    = en & cur_valid & out_ready;

      if (MODE == rrc_pkg::COLLECT_SKIP) begin : g_skip
        assign step_req = sel_hs | ~cur_valid;

        // R3: an idle source is passed over on the next cycle
        a_r3_skip_idle: assert property (@(posedge clk) disable iff (!rst_n)
          (en && !cur_valid) |=>
            (ptr == IDX_W'(rrc_pkg::rrc_wrap_next(int'($past(ptr)), NUM_SRC))));
      end else begin : g_wait
        assign step_req = sel_hs;

        // R1: the waiting policy stays on an idle source
        a_r1_wait_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
          (en && !cur_valid) |=> $stable(ptr));
      end

      rrc_pointer #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .step_req (step_req),
        .ptr      (ptr)
      );

      // R10: a stalled offer keeps the pointer in place
      a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cur_valid && !out_ready) |=> $stable(ptr));
    end
  endgenerate

endmodule

// File: rtl/rrc_mux.sv
module rrc_mux #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IDX_W   = rrc_pkg::rrc_idx_width(NUM_SRC)
) (
  input  logic                      en,
  input  logic [IDX_W-1:0]          sel,
  input  logic                      sel_valid,
  input  logic                      out_ready,
  input  logic [NUM_SRC*DATA_W-1:0] src_data,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data,
  output logic [NUM_SRC-1:0]        src_ready
);

  logic [DATA_W-1:0] lanes [NUM_SRC];
  logic              pass_ready;

  assign pass_ready = en & out_ready;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
      assign lanes[g]     = src_data[g*DATA_W +: DATA_W];
      assign src_ready[g] = pass_ready & (sel == IDX_W'(g));
    end
  endgenerate

  assign out_data  = lanes[sel];
  assign out_valid = en & sel_valid;

endmodule

// File: rtl/rr_stream_collector.sv
module rr_stream_collector #(
  parameter int unsigned            NUM_SRC = 4,
  parameter int unsigned            DATA_W  = 8,
  parameter rrc_pkg::collect_mode_e MODE    = rrc_pkg::COLLECT_WAIT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [NUM_SRC-1:0]        src_valid,
  input  logic [NUM_SRC*DATA_W-1:0] src_data,
  output logic [NUM_SRC-1:0]        src_ready,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data,
  input  logic                      out_ready
);

  localparam int unsigned IDX_W = rrc_pkg::rrc_idx_width(NUM_SRC);

  logic [IDX_W-1:0] sel;
  logic             sel_valid;
  logic             sel_hs;

  rrc_chooser #(.NUM_SRC(NUM_SRC), .MODE(MODE), .IDX_W(IDX_W)) u_choose (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .src_valid (src_valid),
    .out_ready (out_ready),
    .sel       (sel),
    .sel_valid (sel_valid),
    .sel_hs    (sel_hs)
  );

  rrc_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
    .en        (en),
    .sel       (sel),
    .sel_valid (sel_valid),
    .out_ready (out_ready),
    .src_data  (src_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .src_ready (src_ready)
  );

  // R6: the ready goes back to one source at most
  a_r6_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ready));

  // R8: a disabled block offers nothing and accepts nothing
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!out_valid && src_ready == '0));

  // R9: the accepting source is the one the chooser reports
  a_r9_hs_source: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hs |-> (out_valid && src_ready[sel]));

endmodule

// File: tb/tb_rr_stream_collector.sv
module tb_rr_stream_collector;

  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic ordy = 1'b0;
  logic [N-1:0] sv = '0;
  logic [N*W-1:0] sd = '0;

  logic [N-1:0] rdy_w, rdy_s, rdy_p;
  logic ov_w, ov_s, ov_p;
  logic [W-1:0] od_w, od_s, od_p;

  int checks = 0;
  int failures = 0;
  int dcnt = 0;
  int ptr_w = 0;
  int ptr_s = 0;

  always #5 clk = ~clk;

  rr_stream_collector #(.NUM_SRC(N), .DATA_W(W), .MODE(rrc_pkg::COLLECT_WAIT)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .src_valid(sv), .src_data(sd),
    .src_ready(rdy_w), .out_valid(ov_w), .out_data(od_w), .out_ready(ordy));

  rr_stream_collector #(.NUM_SRC(N), .DATA_W(W), .MODE(rrc_pkg::COLLECT_SKIP)) dut_skip (
    .clk(clk), .rst_n(rst_n), .en(en), .src_valid(sv), .src_data(sd),
    .src_ready(rdy_s), .out_valid(ov_s), .out_data(od_s), .out_ready(ordy));

  rr_stream_collector #(.NUM_SRC(N), .DATA_W(W), .MODE(rrc_pkg::COLLECT_PRIO)) dut_par (
    .clk(clk), .rst_n(rst_n), .en(en), .src_valid(sv), .src_data(sd),
    .src_ready(rdy_p), .out_valid(ov_p), .out_data(od_p), .out_ready(ordy));

  function automatic logic [W-1:0] lane_val(input int i, input int c);
    return W'((i << 4) | (c & 15));
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_port(input string tag, input string name, input int sel,
                          input logic ov, input logic [W-1:0] od, input logic [N-1:0] rd);
    logic ev;
    logic [N-1:0] er;
    ev = en & sv[sel];
    er = (en & ordy) ? N'(1 << sel) : '0;
    chk(ov == ev, tag, {name, " out_valid"}, int'(ov), int'(ev));
    if (ev) chk(od == lane_val(sel, dcnt), tag, {name, " out_data"},
                int'(od), int'(lane_val(sel, dcnt)));
    chk(rd == er, "R6", {name, " src_ready"}, int'(rd), int'(er));
  endtask

  task automatic step(input logic [N-1:0] v, input logic r, input logic e,
                      input string tag);
    int win;
    int nw;
    int ns;
    bit hs;
    @(negedge clk);
    sv = v; ordy = r; en = e; dcnt++;
    for (int i = 0; i < N; i++) sd[i*W +: W] = lane_val(i, dcnt);
    #2;
    win = 0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) win = i;
    chk_port(tag, "wait", ptr_w, ov_w, od_w, rdy_w);
    chk_port(tag, "skip", ptr_s, ov_s, od_s, rdy_s);
    chk_port(tag, "prio", win, ov_p, od_p, rdy_p);
    hs = e & v[ptr_w] & r;
    nw = hs ? (ptr_w + 1) % N : ptr_w;
    hs = e & v[ptr_s] & r;
    ns = (e & (hs | ~v[ptr_s])) ? (ptr_s + 1) % N : ptr_s;
    @(posedge clk);
    #1;
    ptr_w = nw;
    ptr_s = ns;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7: first selection after reset is source 0 in every policy
    step(4'b1111, 1'b1, 1'b1, "R7");
    // R5: full rotation and wrap, order 1,2,3,0 for rotation policies
    for (int k = 0; k < 4; k++) step(4'b1111, 1'b1, 1'b1, "R5");
    // R10: offers without ready hold the pointer
    step(4'b1111, 1'b0, 1'b1, "R10");
    step(4'b1111, 1'b0, 1'b1, "R10");
    // R2: idle source 1 blocks the waiting policy
    for (int k = 0; k < 3; k++) step(4'b1101, 1'b1, 1'b1, "R2");
    // R3: skipping policy walks past idle sources
    for (int k = 0; k < 4; k++) step(4'b0001, 1'b1, 1'b1, "R3");
    // R4: lowest valid wins in the priority policy
    step(4'b1100, 1'b1, 1'b1, "R4");
    step(4'b1010, 1'b1, 1'b1, "R4");
    step(4'b0000, 1'b1, 1'b1, "R4");
    // R8: disabled block is silent and frozen
    for (int k = 0; k < 3; k++) step(4'b1111, 1'b1, 1'b0, "R8");
    // R9 / R1: exhaustive sweep of masks, ready and enable
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int m = 0; m < 16; m++)
          step(4'(m), 1'(r), 1'(e == 0 ? 1 : 0), e == 0 ? "R9" : "R8");
    // R1: long pseudo-random run
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0], lf[5] | lf[6], lf[8] | lf[9] | lf[11], "R1");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule